// File: doc/BRIEF.md
# Receive Clock Gating Controller

This block decides, cycle by cycle, whether the receive clock handed to a MAC may toggle. While the link is up but nothing arrives, the gated clock is held low to save power in the MAC. Receive data-valid and data pass through one register stage. The clock enable is formed from the undelayed inputs, so the gated clock is already running one cycle before the delayed data-valid rises.

After the last sign of activity, a hangover counter keeps the clock alive for a fixed number of cycles, 64 by default, and then lets it stop. Activity is either raw data-valid or an early frame-start hint. Gating is active only when the gating control bit is 1 and neither loopback nor PCS bypass is selected. In every other case the clock runs freely. The enable is captured by a latch that is transparent while the clock is low, so the gated clock never shows a partial pulse.

Top module: `rx_clk_gater`

## Requirements
- R1: With `gate_en`=1, no loopback, no bypass, no activity and the hangover expired, `clk_en` is 0 and `gclk` stays low.
- R2: `clk_en` is 1 in the cycle `dv_in` is first presented, which is one cycle before `dv_out` rises. The MAC therefore receives one gated edge before it sees data-valid high.
- R3: After `dv_out` is last high, `clk_en` stays 1 for exactly HANG (64) further cycles and is 0 in the cycle after.
- R4: With `gate_en`=0, `clk_en` is 1 in every cycle, whatever the data inputs do.
- R5: With `loopback`=1 or `pcs_bypass`=1, `clk_en` is 1 in every cycle, whatever the value of `gate_en`.
- R6: `dv_out` and `rxd_out` equal `dv_in` and `rxd_in` from the previous cycle.
- R7: Activity that arrives while a hangover is running leaves no cycle with `clk_en`=0 between the two frames.
- R8: A `sof_early` pulse alone turns `clk_en` on in its own cycle and keeps it on for HANG+1 further cycles. It does not change `dv_out`.
- R9: During synchronous reset `clk_en` is 1 and `dv_out` and `rxd_out` are 0. After reset, no hangover is pending.
- R10: `gclk` is high only while `clk` is high. During a clock-high phase it follows the enable that was present in the preceding low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running receive clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | 1 enables gating, 0 keeps the clock running |
| loopback | input | 1 | Loopback mode; forces the clock on |
| pcs_bypass | input | 1 | PCS bypass mode; forces the clock on |
| sof_early | input | 1 | Early frame-start hint |
| dv_in | input | 1 | Raw receive data-valid |
| rxd_in | input | W | Raw receive data |
| dv_out | output | 1 | Data-valid delayed one cycle |
| rxd_out | output | W | Data delayed one cycle |
| clk_en | output | 1 | Clock enable before the latch |
| gclk | output | 1 | Glitch-free gated receive clock |

## Verification
`clk_en` is combinational on the current inputs and the hangover state, so its expected value belongs to the same cycle the stimulus is driven. `dv_out` and `rxd_out` are due one edge later. The driver applies inputs just after a rising edge and queues the expected values for that cycle. The monitor compares them at the following falling edge, when the inputs and the registers are settled. `gclk` is checked shortly after each rising edge against the enable seen at the falling edge before it. The expected enable comes from the distance to the last active cycle, which is at most HANG+1 cycles.

// File: rtl/rx_clk_gater.sv
module rx_clk_gater #(
  parameter int W    = 4,
  parameter int HANG = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gate_en,
  input  logic         loopback,
  input  logic         pcs_bypass,
  input  logic         sof_early,
  input  logic         dv_in,
  input  logic [W-1:0] rxd_in,
  output logic         dv_out,
  output logic [W-1:0] rxd_out,
  output logic         clk_en,
  output logic         gclk
);
  localparam int CW = $clog2(HANG + 1);
  localparam logic [CW-1:0] HANG_V = CW'(HANG);

  logic          dv_q, act_q, en_lat;
  logic [CW-1:0] cnt;
  logic          act, forced;

  assign act    = dv_in | sof_early;
  assign forced = rst | ~gate_en | loopback | pcs_bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q    <= 1'b0;
      rxd_out <= '0;
      act_q   <= 1'b0;
      cnt     <= '0;
    end else begin
      dv_q    <= dv_in;
      rxd_out <= rxd_in;
      act_q   <= act;
      if (act)
        cnt <= '0;
      else if (act_q)
        cnt <= HANG_V;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign dv_out = dv_q;
  assign clk_en = forced | act | act_q | (cnt != '0);

  always_latch begin
    if (!clk) en_lat = clk_en;
  end

  assign gclk = clk & en_lat;

  assert_lead_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dv_q) |-> $past(clk_en));

  assert_run_during_valid_R3: assert property (@(posedge clk) disable iff (rst)
    dv_q |-> clk_en);

  assert_forced_R4: assert property (@(posedge clk) disable iff (rst)
    (~gate_en | loopback | pcs_bypass) |-> clk_en);

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $past(clk_en) && act |-> clk_en);

  assert_hang_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= HANG_V);

  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> (!dv_q && cnt == '0));

  assert_delay_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (dv_out == $past(dv_in)));
endmodule

// File: tb/rx_clk_gater_bench.sv
`timescale 1ns/100ps
module rx_clk_gater_bench;
  localparam int W = 4;
  localparam int HANG = 64;

  logic clk = 1'b0;
  logic rst, gate_en, loopback, pcs_bypass, sof_early, dv_in;
  logic [W-1:0] rxd_in;
  logic dv_out, clk_en, gclk;
  logic [W-1:0] rxd_out;

  always #2 clk = ~clk;

  rx_clk_gater #(.W(W), .HANG(HANG)) u_rx_clk_gater (
    .clk(clk), .rst(rst), .gate_en(gate_en), .loopback(loopback),
    .pcs_bypass(pcs_bypass), .sof_early(sof_early), .dv_in(dv_in),
    .rxd_in(rxd_in), .dv_out(dv_out), .rxd_out(rxd_out),
    .clk_en(clk_en), .gclk(gclk));

  typedef struct {
    logic en;
    logic dv;
    logic [W-1:0] d;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int cyc = 0, last_act = -1000;
  logic prev_dv = 1'b0;
  logic [W-1:0] prev_d = '0;
  logic en_seen = 1'b1;
  logic done = 1'b0;

  task automatic step(input logic r, input logic dv, input logic sof,
                      input logic [W-1:0] d, input string tag);
    exp_t e;
    @(posedge clk); #1;
    rst = r; dv_in = dv; sof_early = sof; rxd_in = d;
    e.en = r | ~gate_en | loopback | pcs_bypass | dv | sof |
           ((cyc - last_act) <= HANG + 1);
    e.dv = prev_dv;
    e.d  = prev_d;
    e.tag = tag;
    q.push_back(e);
    if (r) begin
      last_act = -1000; prev_dv = 1'b0; prev_d = '0;
    end else begin
      if (dv | sof) last_act = cyc;
      prev_dv = dv; prev_d = d;
    end
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic frame(input int n, input logic [W-1:0] seed, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, W'(seed + W'(i)), tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (clk_en !== e.en) begin
        fails++;
        $display("FAIL %s clk_en cycle %0d: got %b expected %b", e.tag, cyc, clk_en, e.en);
      end
      checks++;
      if (dv_out !== e.dv || rxd_out !== e.d) begin
        fails++;
        $display("FAIL %s/R6 dv/data: got %b/%h expected %b/%h", e.tag, dv_out, rxd_out, e.dv, e.d);
      end
    end
    en_seen = clk_en;
  end

  always @(posedge clk) begin
    #0.5;
    if (!done) begin
      checks++;
      if (gclk !== en_seen) begin
        fails++;
        $display("FAIL R10 gclk high phase: got %b expected %b", gclk, en_seen);
      end
    end
  end

  initial begin
    rst = 1'b1; gate_en = 1'b1; loopback = 1'b0; pcs_bypass = 1'b0;
    sof_early = 1'b0; dv_in = 1'b0; rxd_in = '0;
    fork
      begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0, "R9");
        idle(4, "R1");
        frame(6, 4'h3, "R2");
        idle(HANG + 6, "R3");
        frame(3, 4'hA, "R6");
        idle(20, "R7");
        frame(4, 4'h5, "R7");
        idle(HANG + 4, "R3");
        step(1'b0, 1'b0, 1'b1, '0, "R8");
        idle(HANG + 5, "R8");
        @(posedge clk); #1; gate_en = 1'b0;
        idle(6, "R4");
        frame(2, 4'h1, "R4");
        idle(HANG + 5, "R4");
        @(posedge clk); #1; gate_en = 1'b1; loopback = 1'b1;
        idle(5, "R5");
        @(posedge clk); #1; loopback = 1'b0; pcs_bypass = 1'b1;
        idle(5, "R5");
        @(posedge clk); #1; pcs_bypass = 1'b0;
        idle(3, "R1");
        frame(2, 4'h9, "R2");
        idle(10, "R9");
        step(1'b1, 1'b0, 1'b0, '0, "R9");
        idle(3, "R9");
        @(posedge clk); @(posedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    done = 1'b1;
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule